// File: doc/BRIEF.md
# Serial Converter Register Interface

This block is the digital control port of a two-channel measurement converter. A host reaches it as a serial slave over a clock, a low-active select, a data input and a data output. It also sees an active-low ready flag. Every exchange starts with an 8-bit command byte. The command names one internal register and says whether the next transfer reads or writes it. The same byte also carries a power-down request and an input-channel number. The following transfer then moves exactly as many bits as that register holds. After it, the port waits for a fresh command.

The register set has three parts. The first is a command register, a setup register and a clock-configuration register, each 8 bits wide. The second is a 16-bit result register, which is read-only from the serial side. The conversion engine fills it through a parallel load port. The third is a 24-bit offset register and a 24-bit gain register for each channel. Setup, clock, power-down, channel and the calibration pair of the current channel are all driven out as plain outputs. The analog side uses them from there.

All serial pins are resynchronised into the system clock domain. The serial clock idles high. Each bit is captured on a rising serial edge, and output data moves on falling edges.

Top module: `sadc_regport`

## Requirements
- R1: After reset the stored command fields are zero, `drdy_n` is 1, `cfg_setup` is 0x01, `cfg_clock` is 0x05, every offset register is 0x800000 and every gain register is 0x400000.
- R2: A command byte is sent MSB first. Bit 7 is the start bit and must be 0. Bits 6:4 are the register code, bit 3 is 1 for a read and 0 for a write, bit 2 is power-down and bits 1:0 are the channel. Every accepted command updates `pwr_down` and `chan_sel`.
- R3: A byte received while the port waits for a command is discarded when its bit 7 is 1. It changes no register, and the byte after it is again taken as a command.
- R4: Register codes are 000 command (8 bits), 001 setup (8), 010 clock (8), 011 result (16), 110 offset (24) and 111 gain (24). Codes 100 and 101 take 8 bits and read as 0. A written value appears on the matching output, and a read returns it.
- R5: Offset and gain exist once per channel. Bit 0 of the channel field picks the one accessed, and `cal_offset`/`cal_gain` show the pair of the channel in the last command.
- R6: A write to an offset or gain register is dropped unless setup bits 7:6 are 00 (normal mode).
- R7: A `res_valid` pulse loads `res_data` into the result register and drives `drdy_n` low. Serial writes to the result register are dropped.
- R8: A complete serial read of the result register sets `drdy_n` to 1. If a new result is loaded in the same cycle as that read completes, `drdy_n` stays 0.
- R9: Reading the command register returns `drdy_n` in bit 7 and the stored command bits 6:0 below it.
- R10: `din` is sampled on rising `sclk` and `dout` changes only on falling `sclk`, MSB first. `dout_oe` is 0 whenever `cs_n` is 1.
- R11: Raising `cs_n` in the middle of a transfer drops it without any register change, and the next byte is taken as a command.
- R12: After a complete transfer, or after a command that writes the command register itself (code 000, write), the next byte is taken as a command within the same select period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idle high |
| cs_n | input | 1 | Serial select, active low |
| din | input | 1 | Serial data into the block |
| dout | output | 1 | Serial data out of the block |
| dout_oe | output | 1 | Output enable for `dout` (tri-state control) |
| drdy_n | output | 1 | Result ready, active low |
| res_valid | input | 1 | Parallel result load strobe |
| res_data | input | DATA_W | Parallel result value |
| cfg_setup | output | 8 | Setup register |
| cfg_clock | output | 8 | Clock configuration register |
| pwr_down | output | 1 | Power-down bit of last command |
| chan_sel | output | 2 | Channel field of last command |
| cal_offset | output | CAL_W | Offset register of selected channel |
| cal_gain | output | CAL_W | Gain register of selected channel |

## Verification
Two events can land in the same system cycle: a new result arriving on the parallel port, and the completion of a serial read of the result register. The bench places the result pulse at each of several cycle offsets around the final rising serial edge of a result read. Only the offset that matches the read completion exactly hits the collision. Each case is judged by where `drdy_n` settles and by the value the following read returns. The old result must be read out, and the ready flag must stay low only when the new load is not earlier than the read completion.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    localparam int CMD_W = 8;
    localparam int CFG_W = 8;

    typedef enum logic [2:0] {
        RS_COMM  = 3'd0,
        RS_SETUP = 3'd1,
        RS_CLOCK = 3'd2,
        RS_DATA  = 3'd3,
        RS_NC4   = 3'd4,
        RS_NC5   = 3'd5,
        RS_OFS   = 3'd6,
        RS_GAIN  = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        L_CMD = 2'd0,
        L_RD  = 2'd1,
        L_WR  = 2'd2
    } link_st_e;

    function automatic int xfer_w(reg_sel_e s, int data_w, int cal_w);
        case (s)
            RS_DATA:         return data_w;
            RS_OFS, RS_GAIN: return cal_w;
            default:         return CFG_W;
        endcase
    endfunction

endpackage

// File: rtl/sadc_pin_sync.sv
module sadc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic din,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic din_s
);
    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] cs;
        logic [STAGES-1:0] dat;
        logic              prev;
    } sy_t;

    sy_t sy_d, sy_q;

    always_comb begin
        sy_d      = sy_q;
        sy_d.sck  = {sy_q.sck[STAGES-2:0], sclk};
        sy_d.cs   = {sy_q.cs[STAGES-2:0], cs_n};
        sy_d.dat  = {sy_q.dat[STAGES-2:0], din};
        sy_d.prev = sy_q.sck[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q.sck  <= '1;
            sy_q.cs   <= '1;
            sy_q.dat  <= '0;
            sy_q.prev <= 1'b1;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign cs_act    = ~sy_q.cs[STAGES-1];
    assign din_s     = sy_q.dat[STAGES-1];
    assign sclk_rise = cs_act &  sy_q.sck[STAGES-1] & ~sy_q.prev;
    assign sclk_fall = cs_act & ~sy_q.sck[STAGES-1] &  sy_q.prev;

    // R10: an edge pulse is never high on two cycles in a row
    a_r10_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise || sclk_fall) |=> !(sclk_rise || sclk_fall));

endmodule

// File: rtl/sadc_link.sv
module sadc_link
    import sadc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CAL_W  = 24,
    parameter int MAX_W  = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             cs_act,
    input  logic             din_s,
    input  logic [MAX_W-1:0] rd_word,
    output reg_sel_e         sel,
    output logic             cmd_stb,
    output logic [6:0]       cmd,
    output logic             wr_stb,
    output logic [MAX_W-1:0] wr_word,
    output logic             rd_done,
    output logic             dout
);
    localparam int CW = $clog2(MAX_W + 1);

    typedef struct packed {
        link_st_e         st;
        logic [CW-1:0]    cnt;
        logic [CW-1:0]    last;
        logic [MAX_W-1:0] sh;
        logic [MAX_W-1:0] shin;
        logic             first;
        reg_sel_e         sel;
        logic             cmd_stb;
        logic [6:0]       cmd;
        logic             wr_stb;
        logic             rd_done;
    } lk_t;

    lk_t lk_d, lk_q;
    logic [7:0] byte_w;
    int         rd_shift;

    always_comb begin
        lk_d         = lk_q;
        lk_d.cmd_stb = 1'b0;
        lk_d.wr_stb  = 1'b0;
        lk_d.rd_done = 1'b0;
        byte_w       = {lk_q.shin[6:0], din_s};
        rd_shift     = MAX_W - xfer_w(lk_q.sel, DATA_W, CAL_W);
        if (!cs_act) begin
            lk_d.st    = L_CMD;
            lk_d.cnt   = '0;
            lk_d.first = 1'b0;
        end else begin
            case (lk_q.st)
                L_CMD: if (sclk_rise) begin
                    lk_d.shin = {lk_q.shin[MAX_W-2:0], din_s};
                    if (lk_q.cnt == CW'(CMD_W - 1)) begin
                        lk_d.cnt = '0;
                        if (!byte_w[7]) begin
                            lk_d.cmd_stb = 1'b1;
                            lk_d.cmd     = byte_w[6:0];
                            lk_d.sel     = reg_sel_e'(byte_w[6:4]);
                            lk_d.last    = CW'(xfer_w(reg_sel_e'(byte_w[6:4]), DATA_W, CAL_W) - 1);
                            lk_d.shin    = '0;
                            if (byte_w[3]) begin
                                lk_d.st    = L_RD;
                                lk_d.first = 1'b1;
                            end else if (byte_w[6:4] != 3'd0) begin
                                lk_d.st = L_WR;
                            end
                        end
                    end else begin
                        lk_d.cnt = lk_q.cnt + 1'b1;
                    end
                end
                L_RD: begin
                    if (sclk_fall) begin
                        if (lk_q.first) begin
                            lk_d.sh    = rd_word << rd_shift;
                            lk_d.first = 1'b0;
                        end else begin
                            lk_d.sh = {lk_q.sh[MAX_W-2:0], 1'b0};
                        end
                    end
                    if (sclk_rise) begin
                        if (lk_q.cnt == lk_q.last) begin
                            lk_d.st      = L_CMD;
                            lk_d.cnt     = '0;
                            lk_d.rd_done = (lk_q.sel == RS_DATA);
                        end else begin
                            lk_d.cnt = lk_q.cnt + 1'b1;
                        end
                    end
                end
                L_WR: if (sclk_rise) begin
                    lk_d.shin = {lk_q.shin[MAX_W-2:0], din_s};
                    if (lk_q.cnt == lk_q.last) begin
                        lk_d.st     = L_CMD;
                        lk_d.cnt    = '0;
                        lk_d.wr_stb = 1'b1;
                    end else begin
                        lk_d.cnt = lk_q.cnt + 1'b1;
                    end
                end
                default: lk_d.st = L_CMD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q.st      <= L_CMD;
            lk_q.cnt     <= '0;
            lk_q.last    <= '0;
            lk_q.sh      <= '0;
            lk_q.shin    <= '0;
            lk_q.first   <= 1'b0;
            lk_q.sel     <= RS_COMM;
            lk_q.cmd_stb <= 1'b0;
            lk_q.cmd     <= '0;
            lk_q.wr_stb  <= 1'b0;
            lk_q.rd_done <= 1'b0;
        end else begin
            lk_q <= lk_d;
        end
    end

    assign sel     = lk_q.sel;
    assign cmd_stb = lk_q.cmd_stb;
    assign cmd     = lk_q.cmd;
    assign wr_stb  = lk_q.wr_stb;
    assign wr_word = lk_q.shin;
    assign rd_done = lk_q.rd_done;
    assign dout    = lk_q.sh[MAX_W-1];

    // R10: serial output only moves after a falling serial edge
    a_r10_dout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(dout));
    // R11: deselect forces the command-wait state
    a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (lk_q.st == L_CMD && lk_q.cnt == '0));
    // R12: at most one transfer event per cycle
    a_r12_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_stb, wr_stb, rd_done}));

endmodule

// File: rtl/sadc_regfile.sv
module sadc_regfile
    import sadc_pkg::*;
#(
    parameter int          NCH     = 2,
    parameter int          DATA_W  = 16,
    parameter int          CAL_W   = 24,
    parameter int          MAX_W   = 24,
    parameter logic [23:0] OFS_RST = 24'h800000,
    parameter logic [23:0] GN_RST  = 24'h400000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_sel_e          sel,
    input  logic              cmd_stb,
    input  logic [6:0]        cmd,
    input  logic              wr_stb,
    input  logic [MAX_W-1:0]  wr_word,
    input  logic              rd_done,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    output logic [MAX_W-1:0]  rd_word,
    output logic              drdy_n,
    output logic [7:0]        cfg_setup,
    output logic [7:0]        cfg_clock,
    output logic              pwr_down,
    output logic [1:0]        chan_sel,
    output logic [CAL_W-1:0]  cal_offset,
    output logic [CAL_W-1:0]  cal_gain
);
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        logic [6:0]                comm;
        logic [7:0]                setup;
        logic [7:0]                clkc;
        logic [DATA_W-1:0]         data;
        logic [NCH-1:0][CAL_W-1:0] ofs;
        logic [NCH-1:0][CAL_W-1:0] gain;
        logic                      drdy_n;
    } rf_t;

    rf_t rf_d, rf_q;
    logic [CHW-1:0] idx;
    logic           idx_ok;
    logic           mode_ok;

    assign idx     = rf_q.comm[CHW-1:0];
    assign idx_ok  = (int'(idx) < NCH);
    assign mode_ok = (rf_q.setup[7:6] == 2'b00);

    always_comb begin
        rf_d = rf_q;
        if (cmd_stb) rf_d.comm = cmd;
        if (wr_stb) begin
            case (sel)
                RS_SETUP: rf_d.setup = wr_word[7:0];
                RS_CLOCK: rf_d.clkc  = wr_word[7:0];
                RS_OFS:   if (mode_ok && idx_ok) rf_d.ofs[idx]  = wr_word[CAL_W-1:0];
                RS_GAIN:  if (mode_ok && idx_ok) rf_d.gain[idx] = wr_word[CAL_W-1:0];
                default:  ;
            endcase
        end
        if (res_valid) begin
            rf_d.data   = res_data;
            rf_d.drdy_n = 1'b0;
        end else if (rd_done) begin
            rf_d.drdy_n = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q.comm   <= '0;
            rf_q.setup  <= 8'h01;
            rf_q.clkc   <= 8'h05;
            rf_q.data   <= '0;
            rf_q.drdy_n <= 1'b1;
            for (int i = 0; i < NCH; i++) begin
                rf_q.ofs[i]  <= CAL_W'(OFS_RST);
                rf_q.gain[i] <= CAL_W'(GN_RST);
            end
        end else begin
            rf_q <= rf_d;
        end
    end

    always_comb begin
        case (sel)
            RS_COMM:  rd_word = MAX_W'({rf_q.drdy_n, rf_q.comm});
            RS_SETUP: rd_word = MAX_W'(rf_q.setup);
            RS_CLOCK: rd_word = MAX_W'(rf_q.clkc);
            RS_DATA:  rd_word = MAX_W'(rf_q.data);
            RS_OFS:   rd_word = idx_ok ? MAX_W'(rf_q.ofs[idx])  : '0;
            RS_GAIN:  rd_word = idx_ok ? MAX_W'(rf_q.gain[idx]) : '0;
            default:  rd_word = '0;
        endcase
    end

    assign drdy_n     = rf_q.drdy_n;
    assign cfg_setup  = rf_q.setup;
    assign cfg_clock  = rf_q.clkc;
    assign pwr_down   = rf_q.comm[2];
    assign chan_sel   = rf_q.comm[1:0];
    assign cal_offset = idx_ok ? rf_q.ofs[idx]  : '0;
    assign cal_gain   = idx_ok ? rf_q.gain[idx] : '0;

    // R8: a new result keeps ready asserted even against a completing read
    a_r8_result_wins: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !drdy_n);
    // R8: a completed result read with no new load releases ready
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !res_valid) |=> drdy_n);
    // R7: result register follows the parallel port only
    a_r7_data_load: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (rf_q.data == $past(res_data)));
    a_r7_data_ro: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(rf_q.data));

    for (genvar g = 0; g < NCH; g++) begin : g_cal_chk
        // R6: calibration words frozen outside normal mode
        a_r6_cal_locked: assert property (@(posedge clk) disable iff (!rst_n)
            (rf_q.setup[7:6] != 2'b00) |=> ($stable(rf_q.ofs[g]) && $stable(rf_q.gain[g])));
    end

endmodule

// File: rtl/sadc_regport.sv
module sadc_regport
    import sadc_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int DATA_W      = 16,
    parameter int CAL_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              din,
    output logic              dout,
    output logic              dout_oe,
    output logic              drdy_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    output logic [7:0]        cfg_setup,
    output logic [7:0]        cfg_clock,
    output logic              pwr_down,
    output logic [1:0]        chan_sel,
    output logic [CAL_W-1:0]  cal_offset,
    output logic [CAL_W-1:0]  cal_gain
);
    localparam int MAX_W = (CAL_W > DATA_W) ? CAL_W : DATA_W;

    logic             sclk_rise, sclk_fall, cs_act, din_s;
    logic             cmd_stb, wr_stb, rd_done;
    logic [6:0]       cmd;
    logic [MAX_W-1:0] wr_word, rd_word;
    reg_sel_e         sel;

    sadc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .din_s(din_s)
    );

    sadc_link #(.DATA_W(DATA_W), .CAL_W(CAL_W), .MAX_W(MAX_W)) u_link (
        .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_act(cs_act), .din_s(din_s), .rd_word(rd_word), .sel(sel),
        .cmd_stb(cmd_stb), .cmd(cmd), .wr_stb(wr_stb), .wr_word(wr_word),
        .rd_done(rd_done), .dout(dout)
    );

    sadc_regfile #(.NCH(NCH), .DATA_W(DATA_W), .CAL_W(CAL_W), .MAX_W(MAX_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .sel(sel), .cmd_stb(cmd_stb), .cmd(cmd),
        .wr_stb(wr_stb), .wr_word(wr_word), .rd_done(rd_done),
        .res_valid(res_valid), .res_data(res_data), .rd_word(rd_word),
        .drdy_n(drdy_n), .cfg_setup(cfg_setup), .cfg_clock(cfg_clock),
        .pwr_down(pwr_down), .chan_sel(chan_sel),
        .cal_offset(cal_offset), .cal_gain(cal_gain)
    );

    assign dout_oe = ~cs_n;

    // R10: output driver released whenever the port is deselected
    a_r10_tristate: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !dout_oe);

endmodule

// File: tb/sim_sadc_regport.sv
`timescale 1ns/1ps
module sim_sadc_regport;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1, cs_n = 1'b1, din = 1'b0;
    logic        dout, dout_oe, drdy_n, pwr_down;
    logic        res_valid = 1'b0;
    logic [15:0] res_data = '0;
    logic [7:0]  cfg_setup, cfg_clock;
    logic [1:0]  chan_sel;
    logic [23:0] cal_offset, cal_gain;

    int n_chk = 0, n_bad = 0;
    int hold = 0;
    bit busy = 1'b1;

    // behavioural model
    logic [7:0]  m_setup = 8'h01, m_clk = 8'h05;
    logic [15:0] m_data = '0;
    logic [23:0] m_ofs [2] = '{24'h800000, 24'h800000};
    logic [23:0] m_gain[2] = '{24'h400000, 24'h400000};
    logic        m_drdy = 1'b1, m_pd = 1'b0;
    logic [1:0]  m_ch = 2'b00;

    always #10 clk = ~clk;

    sadc_regport u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
        .dout(dout), .dout_oe(dout_oe), .drdy_n(drdy_n),
        .res_valid(res_valid), .res_data(res_data),
        .cfg_setup(cfg_setup), .cfg_clock(cfg_clock), .pwr_down(pwr_down),
        .chan_sel(chan_sel), .cal_offset(cal_offset), .cal_gain(cal_gain)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // every-clock comparison against the model while the port is idle
    always @(negedge clk) begin
        if (rst_n && !busy) begin
            if (hold > 0) hold--;
            else begin
                check("R8 drdy_n clock", {31'b0, drdy_n}, {31'b0, m_drdy});
                check("R4 cfg_clock clock", {24'b0, cfg_clock}, {24'b0, m_clk});
                check("R4 cfg_setup clock", {24'b0, cfg_setup}, {24'b0, m_setup});
                check("R5 cal_offset clock", {8'b0, cal_offset}, {8'b0, m_ofs[m_ch[0]]});
                check("R5 cal_gain clock", {8'b0, cal_gain}, {8'b0, m_gain[m_ch[0]]});
                check("R2 pd/ch clock", {29'b0, pwr_down, chan_sel}, {29'b0, m_pd, m_ch});
                check("R10 dout_oe idle", {31'b0, dout_oe}, {31'b0, ~cs_n});
            end
        end
    end

    task automatic xfer(input int n, input logic [31:0] wv, output logic [31:0] rv);
        rv = '0;
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk); sclk = 1'b0; din = wv[i];
            repeat (6) @(negedge clk);
            rv[i] = dout;
            sclk = 1'b1;
            repeat (6) @(negedge clk);
        end
    endtask

    task automatic sel_on();
        busy = 1'b1;
        @(negedge clk); cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic sel_off();
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        busy = 1'b0;
    endtask

    task automatic note_cmd(input logic [7:0] c);
        if (!c[7]) begin m_pd = c[2]; m_ch = c[1:0]; end
    endtask

    task automatic wr_reg(input logic [7:0] c, input int n, input logic [31:0] v);
        logic [31:0] r;
        sel_on(); xfer(8, {24'b0, c}, r); xfer(n, v, r); sel_off();
        note_cmd(c);
    endtask

    task automatic rd_reg(input logic [7:0] c, input int n, output logic [31:0] v);
        logic [31:0] r;
        sel_on(); xfer(8, {24'b0, c}, r); xfer(n, 0, v); sel_off();
        note_cmd(c);
    endtask

    task automatic pulse_result(input logic [15:0] v);
        @(negedge clk); res_valid = 1'b1; res_data = v;
        @(negedge clk); res_valid = 1'b0;
        m_data = v; m_drdy = 1'b0; hold = 3;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired got=running exp=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] r, hi;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1 reset state
        check("R1 drdy_n reset", {31'b0, drdy_n}, 32'd1);
        check("R1 setup reset", {24'b0, cfg_setup}, 32'h01);
        check("R1 clock reset", {24'b0, cfg_clock}, 32'h05);
        check("R1 offset reset", {8'b0, cal_offset}, 32'h800000);
        check("R1 gain reset", {8'b0, cal_gain}, 32'h400000);
        check("R10 dout_oe deselected", {31'b0, dout_oe}, 32'd0);
        busy = 1'b0;

        // R9 command readback: drdy high, code 000 read => 0x88
        rd_reg(8'h08, 8, r);
        check("R9 comm readback idle", r, 32'h88);

        // R4 clock and setup write/read
        wr_reg(8'h20, 8, 32'hA5); m_clk = 8'hA5;
        check("R4 clock write", {24'b0, cfg_clock}, 32'hA5);
        rd_reg(8'h28, 8, r);
        check("R4 clock readback", r, 32'hA5);
        wr_reg(8'h10, 8, 32'h04); m_setup = 8'h04;
        rd_reg(8'h18, 8, r);
        check("R4 setup readback", r, 32'h04);
        rd_reg(8'h48, 8, r);
        check("R4 unmapped reads zero", r, 32'h0);

        // R5 per-channel calibration
        wr_reg(8'h60, 24, 32'h123456); m_ofs[0] = 24'h123456;
        wr_reg(8'h61, 24, 32'hABCDEF); m_ofs[1] = 24'hABCDEF;
        check("R5 cal_offset ch1 out", {8'b0, cal_offset}, 32'hABCDEF);
        rd_reg(8'h68, 24, r);
        check("R5 offset ch0 readback", r, 32'h123456);
        wr_reg(8'h71, 24, 32'h0F0F0F); m_gain[1] = 24'h0F0F0F;
        rd_reg(8'h79, 24, r);
        check("R5 gain ch1 readback", r, 32'h0F0F0F);
        rd_reg(8'h78, 24, r);
        check("R5 gain ch0 untouched", r, 32'h400000);

        // R6 calibration locked outside normal mode
        wr_reg(8'h10, 8, 32'h81); m_setup = 8'h81;
        wr_reg(8'h60, 24, 32'hFFFFFF);
        wr_reg(8'h71, 24, 32'h000001);
        rd_reg(8'h68, 24, r);
        check("R6 offset write dropped", r, 32'h123456);
        rd_reg(8'h79, 24, r);
        check("R6 gain write dropped", r, 32'h0F0F0F);
        wr_reg(8'h10, 8, 32'h01); m_setup = 8'h01;

        // R3 leading-one bytes discarded
        sel_on(); xfer(8, 32'hA0, r); xfer(8, 32'h55, r); xfer(8, 32'h00, r); sel_off();
        note_cmd(8'h55);
        check("R3 leading one ignored", {24'b0, cfg_clock}, 32'hA5);
        rd_reg(8'h28, 8, r);
        check("R3 command after discard", r, 32'hA5);

        // R11 abort in mid-transfer
        sel_on(); xfer(8, 32'h20, r); xfer(4, 32'hF, r); sel_off();
        note_cmd(8'h20);
        check("R11 abort no write", {24'b0, cfg_clock}, 32'hA5);
        rd_reg(8'h28, 8, r);
        check("R11 next command ok", r, 32'hA5);

        // R12 command-register write then further command in same select
        sel_on(); xfer(8, 32'h06, r);
        repeat (8) @(negedge clk);
        check("R2 pwr_down from cmd", {31'b0, pwr_down}, 32'd1);
        check("R2 chan_sel from cmd", {30'b0, chan_sel}, 32'd2);
        xfer(8, 32'h28, r); xfer(8, 0, r);
        check("R12 chained read", r, 32'hA5);
        xfer(8, 32'h18, r); xfer(8, 0, r);
        check("R12 second chained read", r, 32'h01);
        sel_off(); note_cmd(8'h18);

        // R7 result load, R9 ready bit
        pulse_result(16'hBEEF);
        repeat (4) @(negedge clk);
        check("R7 drdy_n low on result", {31'b0, drdy_n}, 32'd0);
        rd_reg(8'h08, 8, r);
        check("R9 comm readback ready", r, 32'h08);
        wr_reg(8'h30, 16, 32'h0000);
        check("R7 drdy_n kept after data write", {31'b0, drdy_n}, 32'd0);
        rd_reg(8'h38, 16, r); m_drdy = 1'b1;
        check("R7 data write dropped", r, 32'hBEEF);
        check("R8 drdy_n high after read", {31'b0, drdy_n}, 32'd1);

        // R8 collision sweep: load placed k cycles after the last rising edge
        for (int k = 1; k <= 5; k++) begin
            logic [15:0] a, b;
            a = 16'h1000 + 16'(k); b = 16'h2000 + 16'(k);
            pulse_result(a);
            repeat (6) @(negedge clk);
            sel_on();
            xfer(8, 32'h38, r);
            xfer(15, 0, hi);
            @(negedge clk); sclk = 1'b0; din = 1'b0;
            repeat (6) @(negedge clk);
            r = {hi[30:0], dout};
            sclk = 1'b1;
            repeat (k) @(negedge clk);
            res_valid = 1'b1; res_data = b;
            @(negedge clk); res_valid = 1'b0;
            sel_off();
            note_cmd(8'h38);
            m_data = b;
            m_drdy = (k >= 3) ? 1'b0 : 1'b1;
            check($sformatf("R8 sweep k=%0d old value read", k), r, {16'b0, a});
            check($sformatf("R8 sweep k=%0d drdy_n", k), {31'b0, drdy_n}, {31'b0, m_drdy});
            rd_reg(8'h38, 16, r); m_drdy = 1'b1;
            check($sformatf("R8 sweep k=%0d new value", k), r, {16'b0, b});
        end

        // R10 dout released after all traffic
        check("R10 dout_oe off at end", {31'b0, dout_oe}, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule